// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block reshapes a 32-bit operand on its way into an arithmetic unit or an address adder. A 2-bit kind code picks one of four shift kinds: shift left with zero fill, shift right with zero fill, shift right with sign fill, and rotate right. A 5-bit amount gives the distance. A separate select overrides the kind code. It rotates the operand right by one place through the incoming carry flag, so the flag enters at the top and the old low bit leaves as the carry. Shifting left arithmetically is the same as the left shift.

Next to the shifted value, the block reports the carry from the shifter. This is the last bit pushed out of the word. When the amount is zero, the operand passes through unchanged and the incoming carry is returned. Logical operations that set flags take their carry from this output. The block is purely combinational: both outputs follow the inputs within the same cycle, and it holds no state.

Top module: `bshift_top`

## Requirements
- R1: With kind 00 (left shift) and amount n in 1..31, result is the operand shifted left n places with zeros entering at bit 0, and carry_o is operand bit 32-n.
- R2: With kind 01 (logical right shift) and amount n in 1..31, result is the operand shifted right n places with zeros entering at bit 31, and carry_o is operand bit n-1.
- R3: With kind 10 (arithmetic right shift) and amount n in 1..31, every vacated upper bit is a copy of operand bit 31, and carry_o is operand bit n-1.
- R4: With kind 11 (rotate right) and amount n in 1..31, bits leaving bit 0 re-enter at bit 31, so no bit is lost; carry_o equals result bit 31.
- R5: With amount 0 and rrx_i low, result equals the operand and carry_o equals carry_i, for each of the four kind codes.
- R6: With rrx_i high, result is {carry_i, operand[31:1]} and carry_o is operand bit 0, whatever the kind code and amount.
- R7: The kind code is decoded as 00 left shift, 01 logical right, 10 arithmetic right, 11 rotate right, so the same operand and amount give kind-specific results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand to transform |
| kind_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amount_i | input | 5 | Shift distance, 0 to 31 |
| rrx_i | input | 1 | High selects the one-place rotate through carry, overriding kind and amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Transformed operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Random operands with random kinds and amounts exercise all four kinds at every distance. Each result is compared with a bench model, which catches a wrong stage weight or a wrong fill bit. Directed vectors set only the top bit, only the low bit, or a distinct marker, at distances 1, 16 and 31. These tell left from right and logical from arithmetic, and they show whether rotation wraps or drops bits. Zero-distance and rotate-through-carry vectors are applied with both carry values and with every kind code, which shows that the carry path really selects carry_i or operand bit 0 and that the override wins.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

endpackage

// File: rtl/bshift_rev.sv
// Reverses the bit order of a word; used to turn a left shift into a right shift.
module bshift_rev #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout[i] = din[DATA_W-1-i];
    end
endmodule

// File: rtl/bshift_core.sv
// Logarithmic right shifter: one stage per amount bit, stage k moves by 2**k.
module bshift_core #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    input  logic              rot,
    input  logic              fill,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stage [AMT_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [STEP-1:0] top_bits;
        assign top_bits = rot ? stage[k][STEP-1:0] : {STEP{fill}};
        assign stage[k+1] = amt[k] ? {top_bits, stage[k][DATA_W-1:STEP]} : stage[k];
    end

    assign dout = stage[AMT_W];
endmodule

// File: rtl/bshift_carry.sv
// Picks the last bit pushed out of a right-shifted source, or passes carry in at distance 0.
module bshift_carry #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [AMT_W-1:0]  amt,
    input  logic              cin,
    output logic              cout
);
    always_comb begin
        cout = cin;
        if (amt != '0) begin
            cout = src[amt - AMT_W'(1)];
        end
    end
endmodule

// File: rtl/bshift_top.sv
module bshift_top
    import bshift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [1:0]        kind_i,
    input  logic [AMT_W-1:0]  amount_i,
    input  logic              rrx_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              carry;
    } shift_res_t;

    shift_kind_e       kind;
    logic              is_left;
    logic [DATA_W-1:0] opnd_rev;
    logic [DATA_W-1:0] core_in;
    logic [DATA_W-1:0] core_out;
    logic [DATA_W-1:0] core_out_rev;
    logic              core_rot;
    logic              core_fill;
    logic              amt_carry;
    shift_res_t        res_d;

    assign kind      = shift_kind_e'(kind_i);
    assign is_left   = (kind == SK_LSL);
    assign core_rot  = (kind == SK_ROR);
    assign core_fill = (kind == SK_ASR) ? opnd_i[DATA_W-1] : 1'b0;
    assign core_in   = is_left ? opnd_rev : opnd_i;

    bshift_rev #(.DATA_W(DATA_W)) u_rev_in (
        .din  (opnd_i),
        .dout (opnd_rev)
    );

    bshift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
        .din  (core_in),
        .amt  (amount_i),
        .rot  (core_rot),
        .fill (core_fill),
        .dout (core_out)
    );

    bshift_rev #(.DATA_W(DATA_W)) u_rev_out (
        .din  (core_out),
        .dout (core_out_rev)
    );

    bshift_carry #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_carry (
        .src  (core_in),
        .amt  (amount_i),
        .cin  (carry_i),
        .cout (amt_carry)
    );

    always_comb begin
        res_d.data  = is_left ? core_out_rev : core_out;
        res_d.carry = amt_carry;
        if (rrx_i) begin
            res_d.data  = {carry_i, opnd_i[DATA_W-1:1]};
            res_d.carry = opnd_i[0];
        end
    end

    assign result_o = res_d.data;
    assign carry_o  = res_d.carry;
endmodule

// File: rtl/bshift_chk.sv
module bshift_chk #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input logic [DATA_W-1:0] opnd_i,
    input logic [1:0]        kind_i,
    input logic [AMT_W-1:0]  amount_i,
    input logic              rrx_i,
    input logic              carry_i,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_o
);
    logic active;
    logic nonzero;

    assign active  = !rrx_i;
    assign nonzero = active && (amount_i != '0);

    always_comb begin
        // R5: zero distance leaves operand and carry untouched
        a_r5_zero_pass: assert (!(active && amount_i == '0) ||
                                (result_o == opnd_i && carry_o == carry_i))
            else $error("a_r5_zero_pass");
        // R6: rotate through carry
        a_r6_rrx: assert (!rrx_i ||
                          (result_o[DATA_W-1] == carry_i &&
                           result_o[DATA_W-2:0] == opnd_i[DATA_W-1:1] &&
                           carry_o == opnd_i[0]))
            else $error("a_r6_rrx");
        // R1: left shift vacates bit 0
        a_r1_lsl_low_zero: assert (!(nonzero && kind_i == 2'b00) || !result_o[0])
            else $error("a_r1_lsl_low_zero");
        // R2: logical right shift vacates bit 31
        a_r2_lsr_top_zero: assert (!(nonzero && kind_i == 2'b01) || !result_o[DATA_W-1])
            else $error("a_r2_lsr_top_zero");
        // R3: arithmetic right shift keeps the sign
        a_r3_asr_sign: assert (!(active && kind_i == 2'b10) ||
                               result_o[DATA_W-1] == opnd_i[DATA_W-1])
            else $error("a_r3_asr_sign");
        // R4: rotation keeps every bit and reports the new top bit
        a_r4_ror_keep: assert (!(nonzero && kind_i == 2'b11) ||
                               ($countones(result_o) == $countones(opnd_i) &&
                                carry_o == result_o[DATA_W-1]))
            else $error("a_r4_ror_keep");
    end
endmodule

bind bshift_top bshift_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (.*);

// File: tb/tb_bshift_top.sv
`timescale 1ns/1ps
module tb_bshift_top;
    localparam int W  = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic [W-1:0]  opnd;
    logic [1:0]    kind;
    logic [AW-1:0] amt;
    logic          rrx;
    logic          cin;
    logic [W-1:0]  result;
    logic          cout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    bshift_top dut (
        .opnd_i   (opnd),
        .kind_i   (kind),
        .amount_i (amt),
        .rrx_i    (rrx),
        .carry_i  (cin),
        .result_o (result),
        .carry_o  (cout)
    );

    // Returns {carry, result} from the requirement text.
    function automatic logic [W:0] model(logic [W-1:0] op, logic [1:0] k,
                                         int n, logic r, logic c);
        logic [W-1:0] res;
        logic         co;
        if (r) return {op[0], c, op[W-1:1]};
        if (n == 0) return {c, op};
        case (k)
            2'b00: begin res = op << n; co = op[W-n]; end
            2'b01: begin res = op >> n; co = op[n-1]; end
            2'b10: begin res = W'($signed(op) >>> n); co = op[n-1]; end
            default: begin res = (op >> n) | (op << (W-n)); co = res[W-1]; end
        endcase
        return {co, res};
    endfunction

    task automatic apply(string tag, logic [W-1:0] op, logic [1:0] k,
                         int n, logic r, logic c);
        logic [W:0] exp;
        @(negedge clk);
        opnd = op; kind = k; amt = AW'(n); rrx = r; cin = c;
        #1;
        exp = model(op, k, n, r, c);
        n_checks++;
        if ({cout, result} !== exp) begin
            n_fail++;
            $display("FAIL %s: op=%h kind=%0d amt=%0d rrx=%0b cin=%0b got c=%0b r=%h exp c=%0b r=%h",
                     tag, op, k, n, r, c, cout, result, exp[W], exp[W-1:0]);
        end
    endtask

    function automatic string tag_of(logic [1:0] k, int n, logic r);
        if (r) return "R6";
        if (n == 0) return "R5";
        case (k)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_b5f7));
        opnd = '0; kind = '0; amt = '0; rrx = 1'b0; cin = 1'b0;

        // Idle state: all-zero inputs give zero outputs (R5)
        apply("R5 idle", '0, 2'b00, 0, 1'b0, 1'b0);

        // R1 left shift boundaries
        apply("R1", 32'h0000_0001, 2'b00, 31, 1'b0, 1'b0);
        apply("R1", 32'h8000_0001, 2'b00, 1, 1'b0, 1'b0);
        apply("R1", 32'h0001_8000, 2'b00, 16, 1'b0, 1'b1);
        // R2 logical right
        apply("R2", 32'h8000_0000, 2'b01, 31, 1'b0, 1'b0);
        apply("R2", 32'h8000_0001, 2'b01, 1, 1'b0, 1'b0);
        // R3 arithmetic right, both signs
        apply("R3", 32'h8000_0000, 2'b10, 31, 1'b0, 1'b0);
        apply("R3", 32'h7FFF_0001, 2'b10, 1, 1'b0, 1'b0);
        apply("R3", 32'hC000_8000, 2'b10, 16, 1'b0, 1'b1);
        // R4 rotate wraps
        apply("R4", 32'h0000_0001, 2'b11, 1, 1'b0, 1'b0);
        apply("R4", 32'h0000_0003, 2'b11, 31, 1'b0, 1'b0);
        apply("R4", 32'h1234_5678, 2'b11, 16, 1'b0, 1'b0);
        // R5 zero distance, every kind, both carries
        for (int k = 0; k < 4; k++) begin
            apply("R5", 32'hA5A5_0F0F, 2'(k), 0, 1'b0, 1'b1);
            apply("R5", 32'h5A5A_F0F0, 2'(k), 0, 1'b0, 1'b0);
        end
        // R6 override regardless of kind and amount
        for (int k = 0; k < 4; k++) begin
            apply("R6", 32'h0000_0001, 2'(k), 7 * k, 1'b1, 1'b1);
            apply("R6", 32'hFFFF_FFFE, 2'(k), 31, 1'b1, 1'b0);
        end
        // R7 kind decoding: same operand and distance, distinct outcomes
        for (int k = 0; k < 4; k++) begin
            apply("R7", 32'h0000_0001, 2'(k), 4, 1'b0, 1'b0);
            apply("R7", 32'h8000_0000, 2'(k), 4, 1'b0, 1'b0);
        end

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] op;
            logic [1:0]   k;
            int           n;
            logic         r;
            logic         c;
            op = $urandom;
            k  = 2'($urandom_range(0, 3));
            n  = $urandom_range(0, 31);
            r  = ($urandom_range(0, 7) == 0);
            c  = 1'($urandom_range(0, 1));
            apply(tag_of(k, n, r), op, k, n, r, c);
        end

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule